// File: doc/BRIEF.md
# Phase-Bit Event Ring Consumer

This block drains a power-of-two ring of 64-bit event entries that a separate producer fills. It does not use a producer index. Each entry carries a phase bit, and the producer writes that bit with the value for the current lap of the ring. The consumer keeps an expected phase and a read pointer. It fetches one entry at a time over a memory read port that answers one cycle after the request. If the entry's phase equals the expected phase, the consumer takes the entry. A mismatch means the producer has not reached that slot yet, and the run stops there.

A run begins with a start pulse that carries a quota. Each accepted entry is offered on a valid/ready output together with a one-hot class taken from its type field. The read pointer advances on every handshake. When the pointer wraps back to slot zero, the expected phase inverts. The run ends when the quota is reached or when a stale entry is seen. A one-cycle done pulse then reports how many entries were taken. On the following cycle comes an acknowledge write that carries the queue ID latched at start and the wrapped read index.

The ring storage holds one slot more than the ring size. That last slot is reserved for a status completion record, and the consumer never fetches it. An init pulse returns the queue to its initial state.

Top module: `evq_drain`

## Requirements
- R1: When `init` is pulsed while idle, the read index becomes 0 and the expected phase becomes 0. The next run therefore takes the entry in slot 0 only if its phase bit is 0.
- R2: The phase bit is bit 63 of an entry. An entry is presented only when this bit equals the expected phase. The first mismatching entry ends the run, is not presented, and leaves the read index on that slot.
- R3: Each handshake advances the read index by one. When the index wraps from the last slot to slot 0, the expected phase inverts, so entries of the next lap are accepted with the opposite phase value.
- R4: A run takes at most `quota` entries, even when more valid entries follow. A quota of 0 completes with a count of 0, performs no memory read, and leaves the index unchanged.
- R5: Exactly one cycle after `done`, `ack_valid` is high for one cycle. At that point `ack_qid` equals the `qid` captured at start, and `ack_idx` equals the read index modulo the ring size.
- R6: The type field is bits [3:0]. Code 0 raises `ev_mgmt`, code 1 raises `ev_drv`, and every other code raises `ev_other`. Exactly one of the three is high while `ev_valid` is high.
- R7: While `ev_valid` is high and `ev_ready` is low, `ev_valid` stays high and `ev_data` does not change.
- R8: Memory read addresses stay below 2^RING_LOG2. The status slot at index 2^RING_LOG2 is never fetched.
- R9: `done_count` equals the number of handshakes in the run. A `start` pulse that arrives during a run is ignored and does not cause a second run.
- R10: Out of reset, `ev_valid`, `done`, `ack_valid` and `mem_rd_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| init | input | 1 | Queue initialise; clears index and phase when idle |
| start | input | 1 | Begin a run |
| quota | input | QUOTA_W | Maximum number of entries for the run |
| qid | input | QID_W | Queue ID, latched at start |
| mem_rd_en | output | 1 | Ring read request |
| mem_rd_addr | output | RING_LOG2+1 | Ring slot address |
| mem_rd_data | input | 64 | Entry returned one cycle after the request |
| ev_valid | output | 1 | Entry offered |
| ev_ready | input | 1 | Sink accepts the entry |
| ev_data | output | 64 | Offered entry |
| ev_mgmt | output | 1 | Class: management completion |
| ev_drv | output | 1 | Class: driver generated |
| ev_other | output | 1 | Class: any other type |
| done | output | 1 | Run finished (one cycle) |
| done_count | output | QUOTA_W | Entries taken in the run |
| ack_valid | output | 1 | Acknowledge write strobe |
| ack_qid | output | QID_W | Queue ID for the acknowledge |
| ack_idx | output | RING_LOG2 | Wrapped read index |

## Verification
The hardest situation to reach is the phase inversion across a wrap. The run has to go past the last slot while later entries carry the opposite phase, and stale entries from an earlier lap sit in the ring with the phase the consumer used to expect. The stimulus table chains runs with no reinitialisation. The bench's own index and phase model fills each run's slots with the right lap value and places a stale marker right after them. Cumulative progress therefore crosses the ring boundary several times, sometimes in the middle of a run. Variable stalls on `ev_ready` keep entries waiting, and a start pulse issued during a run checks that a live run cannot be restarted.

// File: rtl/evq_pkg.sv
package evq_pkg;
  localparam int EVQ_TYPE_W = 4;
  localparam logic [EVQ_TYPE_W-1:0] TYPE_MGMT = 4'd0;
  localparam logic [EVQ_TYPE_W-1:0] TYPE_DRV  = 4'd1;

  typedef enum logic [2:0] {
    S_IDLE, S_READ, S_WAIT, S_PRESENT, S_DONE, S_ACK
  } drain_state_t;

  // one-hot class: bit0 management, bit1 driver, bit2 other
  function automatic logic [2:0] evq_classify(input logic [EVQ_TYPE_W-1:0] t);
    case (t)
      TYPE_MGMT: evq_classify = 3'b001;
      TYPE_DRV:  evq_classify = 3'b010;
      default:   evq_classify = 3'b100;
    endcase
  endfunction
endpackage

// File: rtl/evq_cursor.sv
module evq_cursor #(
  parameter int RING_LOG2 = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 init,
  input  logic                 advance,
  output logic [RING_LOG2-1:0] ptr,
  output logic                 phase,
  output logic                 wrap
);
  function automatic logic [RING_LOG2-1:0] ptr_step(input logic [RING_LOG2-1:0] p);
    ptr_step = p + 1'b1;
  endfunction

  logic [RING_LOG2-1:0] ptr_nxt;
  assign ptr_nxt = ptr_step(ptr);
  assign wrap    = advance && (ptr_nxt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n || init) begin
      ptr   <= '0;
      phase <= 1'b0;
    end else if (advance) begin
      ptr <= ptr_nxt;
      if (wrap) phase <= ~phase;
    end
  end
endmodule

// File: rtl/evq_classify.sv
module evq_classify
  import evq_pkg::*;
(
  input  logic [EVQ_TYPE_W-1:0] typ,
  output logic                  is_mgmt,
  output logic                  is_drv,
  output logic                  is_other
);
  logic [2:0] cls;
  assign cls      = evq_classify(typ);
  assign is_mgmt  = cls[0];
  assign is_drv   = cls[1];
  assign is_other = cls[2];
endmodule

// File: rtl/evq_drain.sv
module evq_drain
  import evq_pkg::*;
#(
  parameter int RING_LOG2 = 4,
  parameter int QUOTA_W   = 8,
  parameter int QID_W     = 8,
  parameter int ENTRY_W   = 64,
  parameter int PHASE_POS = 63,
  parameter int TYPE_LSB  = 0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 init,
  input  logic                 start,
  input  logic [QUOTA_W-1:0]   quota,
  input  logic [QID_W-1:0]     qid,
  output logic                 mem_rd_en,
  output logic [RING_LOG2:0]   mem_rd_addr,
  input  logic [ENTRY_W-1:0]   mem_rd_data,
  output logic                 ev_valid,
  input  logic                 ev_ready,
  output logic [ENTRY_W-1:0]   ev_data,
  output logic                 ev_mgmt,
  output logic                 ev_drv,
  output logic                 ev_other,
  output logic                 done,
  output logic [QUOTA_W-1:0]   done_count,
  output logic                 ack_valid,
  output logic [QID_W-1:0]     ack_qid,
  output logic [RING_LOG2-1:0] ack_idx
);
  drain_state_t         state;
  logic [QUOTA_W-1:0]   run_quota;
  logic [QUOTA_W-1:0]   count;
  logic [QID_W-1:0]     run_qid;
  logic [ENTRY_W-1:0]   entry_q;
  logic [RING_LOG2-1:0] rd_ptr;
  logic                 exp_phase;
  logic                 wrap_evt;
  logic                 take;
  logic                 phase_hit;
  logic                 last_take;

  assign take      = (state == S_PRESENT) && ev_ready;
  assign phase_hit = (mem_rd_data[PHASE_POS] == exp_phase);
  assign last_take = (QUOTA_W'(count + 1'b1) == run_quota);

  evq_cursor #(.RING_LOG2(RING_LOG2)) u_cursor (
    .clk     (clk),
    .rst_n   (rst_n),
    .init    (init && (state == S_IDLE)),
    .advance (take),
    .ptr     (rd_ptr),
    .phase   (exp_phase),
    .wrap    (wrap_evt)
  );

  evq_classify u_class (
    .typ      (entry_q[TYPE_LSB +: EVQ_TYPE_W]),
    .is_mgmt  (ev_mgmt),
    .is_drv   (ev_drv),
    .is_other (ev_other)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      run_quota <= '0;
      count     <= '0;
      run_qid   <= '0;
      entry_q   <= '0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          run_quota <= quota;
          run_qid   <= qid;
          count     <= '0;
          state     <= (quota == '0) ? S_DONE : S_READ;
        end
        S_READ: state <= S_WAIT;
        S_WAIT: begin
          if (phase_hit) begin
            entry_q <= mem_rd_data;
            state   <= S_PRESENT;
          end else begin
            state <= S_DONE;
          end
        end
        S_PRESENT: if (ev_ready) begin
          count <= count + 1'b1;
          state <= last_take ? S_DONE : S_READ;
        end
        S_DONE:  state <= S_ACK;
        S_ACK:   state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign mem_rd_en   = (state == S_READ);
  assign mem_rd_addr = {1'b0, rd_ptr};
  assign ev_valid    = (state == S_PRESENT);
  assign ev_data     = entry_q;
  assign done        = (state == S_DONE);
  assign done_count  = count;
  assign ack_valid   = (state == S_ACK);
  assign ack_qid     = run_qid;
  assign ack_idx     = rd_ptr;
endmodule

// File: rtl/evq_drain_chk.sv
module evq_drain_chk #(
  parameter int RING_LOG2 = 4,
  parameter int QUOTA_W   = 8,
  parameter int ENTRY_W   = 64,
  parameter int PHASE_POS = 63
) (
  input logic               clk,
  input logic               rst_n,
  input logic               ev_valid,
  input logic               ev_ready,
  input logic [ENTRY_W-1:0] ev_data,
  input logic [2:0]         cls,
  input logic               done,
  input logic [QUOTA_W-1:0] done_count,
  input logic [QUOTA_W-1:0] run_quota,
  input logic               ack_valid,
  input logic               mem_rd_en,
  input logic [RING_LOG2:0] mem_rd_addr,
  input logic               exp_phase,
  input logic               wrap_evt
);
  localparam logic [RING_LOG2:0] STATUS_SLOT = (RING_LOG2+1)'(1) << RING_LOG2;

  p_phase_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid |-> ev_data[PHASE_POS] == exp_phase);
  p_wrap_flip_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> exp_phase != $past(exp_phase));
  p_quota_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> done_count <= run_quota);
  p_ack_follows_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> ack_valid);
  p_one_class_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid |-> $countones(cls) == 1);
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && !ev_ready) |=> (ev_valid && $stable(ev_data)));
  p_no_status_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> mem_rd_addr < STATUS_SLOT);
endmodule

bind evq_drain evq_drain_chk #(
  .RING_LOG2(RING_LOG2), .QUOTA_W(QUOTA_W), .ENTRY_W(ENTRY_W), .PHASE_POS(PHASE_POS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_ready(ev_ready),
  .ev_data(ev_data), .cls({ev_other, ev_drv, ev_mgmt}), .done(done),
  .done_count(done_count), .run_quota(run_quota), .ack_valid(ack_valid),
  .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .exp_phase(exp_phase),
  .wrap_evt(wrap_evt)
);

// File: tb/sim_evq_drain.sv
`timescale 1ns/1ps
module sim_evq_drain;
  localparam int L = 4;
  localparam int SZ = 1 << L;
  localparam int NV = 8;
  localparam int VQ[NV] = '{4, 2, 10, 15, 8, 1, 6, 12};
  localparam int VN[NV] = '{3, 5, 10, 15, 12, 1, 0, 9};

  logic clk = 0, rst_n = 0, init = 0, start = 0, ev_ready = 0;
  logic [7:0] quota = 0, qid = 0;
  logic mem_rd_en, ev_valid, ev_mgmt, ev_drv, ev_other, done, ack_valid;
  logic [L:0] mem_rd_addr;
  logic [63:0] mem_rd_data, ev_data;
  logic [7:0] done_count, ack_qid;
  logic [L-1:0] ack_idx;

  logic [63:0] mem [0:SZ];
  int errs = 0, checks = 0;
  int bp = 0, bph = 0, gseq = 0;
  logic [63:0] expd [0:15];
  bit finished = 0;

  always #2.5 clk = ~clk;

  always_ff @(posedge clk) if (mem_rd_en) mem_rd_data <= mem[mem_rd_addr];

  evq_drain u0 (.*);

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run(input int q, input int n, input bit poke, input logic [7:0] id);
    int c, idx, stall, t, p;
    bit got_done, rd_seen, poked;
    c = (n < q) ? n : q;
    for (int i = 0; i < n; i++) begin
      p = bph ^ (((bp + i) / SZ) & 1);
      expd[i] = {p[0], 7'h0, 24'(gseq), 28'h0, 4'((gseq) % 5)};
      gseq++;
      mem[(bp + i) % SZ] = expd[i];
    end
    p = bph ^ (((bp + n) / SZ) & 1);
    mem[(bp + n) % SZ] = {~p[0], 63'h0};
    @(negedge clk); start = 1; quota = 8'(q); qid = id;
    @(negedge clk); start = 0;
    idx = 0; stall = 1; got_done = 0; rd_seen = 0; poked = 0;
    for (t = 0; t < 2000; t++) begin
      start = 0;
      if (mem_rd_en) begin
        rd_seen = 1;
        if (mem_rd_addr >= SZ) chk(0, "R8", mem_rd_addr, 0);
      end
      if (ev_valid) begin
        if (poke && !poked) begin start = 1; quota = 1; poked = 1; end
        if (stall > 0) begin stall--; ev_ready = 0; end
        else begin
          ev_ready = 1;
          chk(ev_data === expd[idx], "R2/R3 data", ev_data, expd[idx]);
          chk({ev_other, ev_drv, ev_mgmt} ===
              ((expd[idx][3:0] == 0) ? 3'b001 : (expd[idx][3:0] == 1) ? 3'b010 : 3'b100),
              "R6 class", {ev_other, ev_drv, ev_mgmt}, expd[idx][3:0]);
          idx++;
          stall = idx % 3;
        end
      end else ev_ready = 0;
      if (done) begin
        got_done = 1;
        chk(done_count == 8'(c), "R4/R9 count", done_count, c);
        chk(idx == c, "R9 handshakes", idx, c);
      end
      if (ack_valid) begin
        bp = bp + c;
        if (bp >= SZ) begin bp -= SZ; bph ^= 1; end
        chk(got_done, "R5 order", 0, 1);
        chk(ack_qid == id, "R5 qid", ack_qid, id);
        chk(ack_idx == L'(bp), "R5/R3 idx", ack_idx, bp);
        if (q == 0) chk(!rd_seen, "R4 no read", rd_seen, 0);
        break;
      end
      @(negedge clk);
    end
    if (t >= 2000) chk(0, "watchdog", t, 0);
    if (poke) begin
      for (int k = 0; k < 6; k++) begin
        @(negedge clk);
        if (done || mem_rd_en) chk(0, "R9 busy start", 1, 0);
      end
      checks++;
    end
    @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i <= SZ; i++) mem[i] = {1'b1, 63'h0};
    mem[SZ] = 64'hFFFF_FFFF_FFFF_FFFF;
    repeat (3) @(negedge clk);
    chk(!ev_valid && !done && !ack_valid && !mem_rd_en, "R10 reset",
        {ev_valid, done, ack_valid, mem_rd_en}, 0);
    rst_n = 1;
    @(negedge clk);
    for (int r = 0; r < NV; r++) run(VQ[r], VN[r], r == 4, 8'(8'h30 + r));
    // R1: init returns index and phase to zero
    @(negedge clk); init = 1; @(negedge clk); init = 0;
    bp = 0; bph = 0;
    run(2, 2, 0, 8'hA1);
    // R4: zero quota
    run(0, 3, 0, 8'hB2);
    // R3: long run across a wrap after init
    run(15, 15, 0, 8'hC3);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      errs++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule